// File: doc/BRIEF.md
# Timer Compare Unit with Pin Action

This block watches a free-running timer value and compares it, on every clock, against a programmable compare register of the same width. When the two become equal, the block carries out an action chosen by a 4-bit mode field. It can drive an output pin high or low, or leave the pin alone. It also raises a sticky interrupt flag. In special-event mode it additionally requests a timer reset.

The timer, the pad tristate control and the bus decode sit outside the block. The enclosing logic supplies the timer value and a write strobe for the compare register. It also supplies the mode field and a strobe that clears the flag. A mode field of all zeros returns the pin latch to its low default. Software uses this all-zero mode to park the output before it selects a new action.

Top module: `tcmp_top`

## Requirements
- R1: The timer is compared with the compare register on every cycle. A match event occurs only on the first cycle in which they are equal. A timer that stays at the compare value produces no further event.
- R2: When `cmp_we_i` is high, `cmp_wdata_i` is loaded into the compare register. The new value takes part in the comparison from the following cycle.
- R3: With mode 4'b1000, a match event makes `pin_o` high from the next cycle.
- R4: With mode 4'b1001, a match event makes `pin_o` low from the next cycle.
- R5: With mode 4'b1010, a match event leaves `pin_o` unchanged.
- R6: In the modes 4'b1000 to 4'b1011, a match event sets `flag_o` from the next cycle, which is the same cycle in which the pin action becomes visible. In any other mode a match event does not set the flag.
- R7: With mode 4'b0000, `pin_o` is low from the next cycle. In every mode other than 4'b0000, 4'b1000 and 4'b1001, the pin holds its value.
- R8: With mode 4'b1011, a match event produces a one-cycle pulse on `timer_rst_o` in the next cycle and leaves the pin unchanged. The block has no timer overflow output.
- R9: `flag_clr_i` clears `flag_o` from the next cycle. If a flag-setting match event occurs in the same cycle, the set wins.
- R10: While `rst_ni` is low, `pin_o`, `flag_o` and `timer_rst_o` are low and the compare register holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_i | input | 16 | Current timer value |
| cmp_wdata_i | input | 16 | Compare register write data |
| cmp_we_i | input | 1 | Compare register write strobe |
| mode_i | input | 4 | Action mode select |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| pin_o | output | 1 | Output latch level for the pin |
| flag_o | output | 1 | Sticky interrupt flag |
| timer_rst_o | output | 1 | One-cycle timer reset request |

## Verification
The assertions check on every cycle how a match event acts on the outputs. They cover the pin direction for the set and clear modes, the pin holding still in flag-only and special-event modes, the flag setting and the forced low in the all-zero mode. They also cover the single-cycle width of the timer reset pulse, the priority of a set over a clear, and the rule that match events never come on two cycles in a row.

Only the bench scenarios can show that a timer held at the compare value fires once and no more. The same is true of the one-cycle delay before a new compare value takes effect. The bench shows both by sweeping every mode through approach, hold and departure sequences and comparing against an arithmetic model.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [3:0] {
    MODE_OFF  = 4'b0000,
    MODE_SET  = 4'b1000,
    MODE_CLR  = 4'b1001,
    MODE_FLAG = 4'b1010,
    MODE_EVT  = 4'b1011
  } tcmp_mode_e;

  // compare modes share the 2'b10 prefix
  function automatic logic is_cmp_mode(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] timer_i,
  input  logic [W-1:0] wdata_i,
  input  logic         we_i,
  output logic         match_o
);
  logic [W-1:0] cmp_q;
  logic         eq, eq_q;

  assign eq      = (timer_i == cmp_q);
  assign match_o = eq & ~eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      eq_q <= eq;
      if (we_i) cmp_q <= wdata_i;
    end
  end
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       match_i,
  output logic       set_o,
  output logic       clr_o,
  output logic       flag_set_o,
  output logic       trig_o,
  output logic       force_low_o
);
  always_comb begin
    set_o       = 1'b0;
    clr_o       = 1'b0;
    trig_o      = 1'b0;
    force_low_o = (mode_i == MODE_OFF);
    flag_set_o  = match_i & is_cmp_mode(mode_i);
    if (match_i) begin
      unique case (mode_i)
        MODE_SET: set_o  = 1'b1;
        MODE_CLR: clr_o  = 1'b1;
        MODE_EVT: trig_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcmp_latch.sv
module tcmp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_low_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q <= 1'b0;
    else if (force_low_i) q <= 1'b0;
    else if (set_i)       q <= 1'b1;
    else if (clr_i)       q <= 1'b0;
  end

  assign q_o = q;
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] timer_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         cmp_we_i,
  input  logic [3:0]   mode_i,
  input  logic         flag_clr_i,
  output logic         pin_o,
  output logic         flag_o,
  output logic         timer_rst_o
);
  logic match, set, clr, flag_set, trig, force_low;
  logic flag_q, trst_q;

  tcmp_match #(.W(W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .timer_i (timer_i),
    .wdata_i (cmp_wdata_i),
    .we_i    (cmp_we_i),
    .match_o (match)
  );

  tcmp_action u_action (
    .mode_i      (mode_i),
    .match_i     (match),
    .set_o       (set),
    .clr_o       (clr),
    .flag_set_o  (flag_set),
    .trig_o      (trig),
    .force_low_o (force_low)
  );

  tcmp_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set),
    .clr_i       (clr),
    .force_low_i (force_low),
    .q_o         (pin_o)
  );

  // set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      trst_q <= 1'b0;
    end else begin
      trst_q <= trig;
      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o      = flag_q;
  assign timer_rst_o = trst_q;
endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       match_i,
  input logic [3:0] mode_i,
  input logic       flag_clr_i,
  input logic       pin_o,
  input logic       flag_o,
  input logic       timer_rst_o
);
  a_r1_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> !match_i);
  a_r3_set_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == 4'b1000) |=> pin_o);
  a_r4_clr_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == 4'b1001) |=> !pin_o);
  a_r5_pin_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b1010) |=> $stable(pin_o));
  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i[3:2] == 2'b10) |=> flag_o);
  a_r7_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0000) |=> !pin_o);
  a_r8_trig_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_rst_o |-> $past(match_i && mode_i == 4'b1011));
  a_r8_trig_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_rst_o |=> !timer_rst_o);
  a_r8_pin_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b1011) |=> $stable(pin_o));
  a_r9_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(match_i && mode_i[3:2] == 2'b10)) |=> !flag_o);
  always_comb begin
    if (!rst_ni) begin
      a_r10_reset_outs: assert (!pin_o && !flag_o && !timer_rst_o);
    end
  end
endmodule

bind tcmp_top tcmp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .match_i     (match),
  .mode_i      (mode_i),
  .flag_clr_i  (flag_clr_i),
  .pin_o       (pin_o),
  .flag_o      (flag_o),
  .timer_rst_o (timer_rst_o)
);

// File: tb/tb_tcmp_top.sv
module tb_tcmp_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] timer_i = 16'h0005;
  logic [15:0] cmp_wdata_i = '0;
  logic        cmp_we_i = 1'b0;
  logic [3:0]  mode_i = 4'b0000;
  logic        flag_clr_i = 1'b0;
  logic        pin_o, flag_o, timer_rst_o;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [15:0] m_cmp = '0;
  logic        m_eqd = 1'b0, m_pin = 1'b0, m_flag = 1'b0, m_trst = 1'b0, m_wlast = 1'b0;

  always #4 clk_i = ~clk_i;

  tcmp_top dut (
    .clk_i, .rst_ni, .timer_i, .cmp_wdata_i, .cmp_we_i,
    .mode_i, .flag_clr_i, .pin_o, .flag_o, .timer_rst_o
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [15:0] t, input logic we, input logic [15:0] wd,
                     input logic [3:0] md, input logic clr);
    logic eq, mt, fset;
    string tp, tf;
    timer_i = t; cmp_we_i = we; cmp_wdata_i = wd; mode_i = md; flag_clr_i = clr;
    eq   = (t == m_cmp);
    mt   = eq && !m_eqd;
    fset = mt && (md[3:2] == 2'b10);
    if (md == 4'b0000)              begin m_pin = 1'b0; tp = "R7"; end
    else if (mt && md == 4'b1000)   begin m_pin = 1'b1; tp = "R3"; end
    else if (mt && md == 4'b1001)   begin m_pin = 1'b0; tp = "R4"; end
    else if (mt && md == 4'b1010)   tp = "R5";
    else if (mt && md == 4'b1011)   tp = "R8";
    else                            tp = "R7";
    if (fset)          begin m_flag = 1'b1; tf = clr ? "R9" : "R6"; end
    else if (clr)      begin m_flag = 1'b0; tf = "R9"; end
    else if (eq && !mt) tf = "R1";
    else if (m_wlast)  tf = "R2";
    else               tf = "R6";
    m_trst  = mt && (md == 4'b1011);
    m_eqd   = eq;
    m_wlast = we;
    if (we) m_cmp = wd;
    @(negedge clk_i);
    chk(tp, pin_o, m_pin, "pin_o");
    chk(tf, flag_o, m_flag, "flag_o");
    chk("R8", timer_rst_o, m_trst, "timer_rst_o");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [15:0] base;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk_i);
    // R10: outputs low during reset
    chk("R10", pin_o, 1'b0, "pin_o in reset");
    chk("R10", flag_o, 1'b0, "flag_o in reset");
    chk("R10", timer_rst_o, 1'b0, "timer_rst_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", pin_o, 1'b0, "pin_o after reset");

    // sweep every mode through approach, hold, leave, re-hit
    for (int md = 0; md < 16; md++) begin
      base = 16'h0040 + 16'(md);
      cyc(16'h0000, 1'b1, base, 4'(md), 1'b1);        // R2 load
      cyc(base - 16'd2, 1'b0, '0, 4'(md), 1'b0);
      cyc(base - 16'd1, 1'b0, '0, 4'(md), 1'b0);
      cyc(base,         1'b0, '0, 4'(md), 1'b0);      // event
      cyc(base,         1'b0, '0, 4'(md), 1'b1);      // R1 hold, clear
      cyc(base,         1'b0, '0, 4'(md), 1'b0);
      cyc(base + 16'd1, 1'b0, '0, 4'(md), 1'b0);
      cyc(base,         1'b0, '0, 4'(md), 1'b1);      // R9 set beats clear
      cyc(base + 16'd3, 1'b0, '0, 4'(md), 1'b1);
      cyc(base + 16'd3, 1'b1, base + 16'd3, 4'(md), 1'b0); // R2 write equal to timer
      cyc(base + 16'd3, 1'b0, '0, 4'(md), 1'b0);
      cyc(base + 16'd4, 1'b0, '0, 4'(md), 1'b0);
      cyc(base + 16'd4, 1'b0, '0, 4'b1000, 1'b0);
      cyc(base + 16'd3, 1'b0, '0, 4'b1000, 1'b1);     // pin high
      cyc(base + 16'd5, 1'b0, '0, 4'(md), 1'b0);      // R7 other modes hold / off forces low
    end

    // dense pseudo-random run over a small timer range
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] md;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[6:4])
        3'd0: md = 4'b0000;
        3'd1: md = 4'b1000;
        3'd2: md = 4'b1001;
        3'd3: md = 4'b1010;
        3'd4: md = 4'b1011;
        3'd5: md = {1'b0, lfsr[9:7]};
        default: md = lfsr[2] ? 4'b1000 : 4'b1001;
      endcase
      cyc({13'd0, lfsr[2:0]}, lfsr[11] & lfsr[12], {13'd0, lfsr[15:13]}, md, lfsr[8] & lfsr[3]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule